// File: doc/BRIEF.md
# Narrow Flow-Control Frame Receiver

This block sits at the receive end of a four-bit flow-control link. Each cycle it samples one nibble, a per-nibble parity bit and a start-of-frame marker. It rebuilds 16-bit words from groups of four nibbles and works out where each frame ends from the length field in the frame's first word. Every frame closes with a check word. Frames that arrive intact are handed to a local consumer through a small ingress FIFO. Frames that arrive damaged, and frames that do not fit, are removed from the FIFO without leaving any trace in it.

Words are written into the FIFO as they arrive, but they are written speculatively. A separate committed pointer marks the data the consumer may see. That pointer moves forward only when the check word confirms the frame. On any failure the write pointer falls back to the committed pointer, so the whole frame disappears. Idle frames carry no information and are never stored. The block raises a backpressure output toward the far transmitter whenever the committed fill level reaches a programmable high-water mark. Running counts of accepted frames, parity-failed frames and dropped frames are also available, together with a sticky overflow flag.

Top module: `fc_nib_rx`

## Requirements
- R1: A frame starts on a cycle where `linkSof` is 1 and no frame is in progress. `linkSof` is ignored while a frame is in progress. Cycles with `linkSof` at 0 between frames are dead cycles and change nothing.
- R2: Each word is built from four consecutive nibbles. The first nibble becomes bits 15:12 and the last nibble becomes bits 3:0.
- R3: Each nibble must satisfy odd parity: `linkNib` and `linkPar` together contain an odd number of ones. If any nibble in a non-idle frame fails this check, the whole frame is dropped, and both `parErrCnt` and `dropCnt` increase by one.
- R4: The first word is the header. Bits 15:12 hold the frame type, and bits 3:0 hold N, the number of payload words (0 to 15). A frame is the header, then N payload words, then one check word, for 4*(N+2) nibbles in total.
- R5: The check word must equal the bitwise XOR of the header and all payload words. If it does not, the whole frame is dropped, and both `parErrCnt` and `dropCnt` increase by one.
- R6: For a good non-idle frame, the header and the payload words enter the FIFO in arrival order. They become readable only after the clock edge that samples the last nibble, and `acceptCnt` increases by one at that edge.
- R7: A frame whose type is 0 is idle. It is never stored and changes no counter.
- R8: A frame that meets a full FIFO is dropped whole. The dropped frame sets `ovfSticky`, which stays at 1 until reset, and increases `dropCnt` by one. Data committed before that frame stays readable and unchanged.
- R9: `fcBackpressure` is 1 exactly when the committed FIFO occupancy is greater than or equal to `hwmLevel`.
- R10: `rdValid` is 1 while committed data is present, and `rdData` shows the oldest committed word. When `rdEn` is sampled high while `rdValid` is 1, that word is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkSof | input | 1 | Start-of-frame marker from the link |
| linkNib | input | 4 | Link data nibble |
| linkPar | input | 1 | Odd parity for the nibble |
| hwmLevel | input | PTR_W+1 (5) | High-water mark, compared against the committed fill level |
| rdEn | input | 1 | Removes the head word |
| rdData | output | 16 | Head word of the FIFO |
| rdValid | output | 1 | Committed data is present |
| fcBackpressure | output | 1 | Asks the far transmitter to stop sending |
| ovfSticky | output | 1 | Set when a frame has been dropped for lack of space |
| acceptCnt | output | CNT_W (8) | Number of frames committed |
| parErrCnt | output | CNT_W (8) | Number of frames that failed nibble or vertical parity |
| dropCnt | output | CNT_W (8) | Number of non-idle frames dropped for any reason |

## Verification
The hardest case to reach from the ports is a frame that collides with a completely full FIFO while earlier data is still waiting to be read. That collision exercises both the rollback path and the check that committed words survive it. The stimulus reaches it by sending one maximum-length frame whose header and fifteen payload words fill the sixteen-entry FIFO exactly. A short frame follows at once, with nothing read in between, and the bench then drains the FIFO word by word. Other directed frames corrupt a single chosen nibble or the check word, and one frame re-asserts start-of-frame partway through, so that each path that drops or ignores input is driven on its own.

// File: rtl/fc_nib_rx_pkg.sv
package fc_nib_rx_pkg;
  localparam int WORD_W = 16;

  // Strobes from control to the FIFO datapath
  typedef struct packed {
    logic              push;
    logic              commit;
    logic              rollback;
    logic [WORD_W-1:0] word;
  } fcStrobe_t;
endpackage

// File: rtl/fc_nib_rx_fifo.sv
module fc_nib_rx_fifo
  import fc_nib_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcStrobe_t         strobe,
  input  logic              rdEn,
  input  logic [PTR_W:0]    hwmLevel,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              specFull,
  output logic              fcBackpressure
);
  localparam logic [PTR_W:0] DEPTH_V = DEPTH[PTR_W:0];

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W:0] wrPtr, cmtPtr, rdPtr;
  logic [PTR_W:0] specLevel, cmtLevel;
  logic pop;

  assign specLevel      = wrPtr - rdPtr;
  assign cmtLevel       = cmtPtr - rdPtr;
  assign specFull       = (specLevel == DEPTH_V);
  assign rdValid        = (rdPtr != cmtPtr);
  assign pop            = rdEn && rdValid;
  assign rdData         = mem[rdPtr[PTR_W-1:0]];
  assign fcBackpressure = (cmtLevel >= hwmLevel);

  always_ff @(posedge clk) begin
    if (strobe.push && !specFull) mem[wrPtr[PTR_W-1:0]] <= strobe.word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      cmtPtr <= '0;
      rdPtr  <= '0;
    end else begin
      if (strobe.rollback)                  wrPtr <= cmtPtr;
      else if (strobe.push && !specFull)    wrPtr <= wrPtr + 1'b1;
      if (strobe.commit)                    cmtPtr <= wrPtr;
      if (pop)                              rdPtr <= rdPtr + 1'b1;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    specLevel <= DEPTH_V);
  p_commit_visible_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrPtr != cmtPtr) |=> rdValid);
  p_rollback_restore_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> (wrPtr == $past(cmtPtr)));
endmodule

// File: rtl/fc_nib_rx_ctrl.sv
module fc_nib_rx_ctrl
  import fc_nib_rx_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkSof,
  input  logic [3:0]       linkNib,
  input  logic             linkPar,
  input  logic             specFull,
  output fcStrobe_t        strobe,
  output logic             ovfSticky,
  output logic [CNT_W-1:0] acceptCnt,
  output logic [CNT_W-1:0] parErrCnt,
  output logic [CNT_W-1:0] dropCnt
);
  typedef enum logic {S_IDLE, S_FRAME} state_t;

  state_t            state;
  logic [1:0]        nibCnt;
  logic [11:0]       shReg;
  logic [LEN_W:0]    wordIdx;
  logic [LEN_W-1:0]  lenWords;
  logic              isIdle, badPar, ovfFrame;
  logic [WORD_W-1:0] vpAcc;

  logic [WORD_W-1:0] curWord;
  logic nibBad, wordDone, headWord, lastWord, dataWord, frameIdle, badNow, vpOk;

  assign nibBad    = ~(^{linkNib, linkPar});
  assign curWord   = {shReg, linkNib};
  assign wordDone  = (state == S_FRAME) && (nibCnt == 2'd3);
  assign headWord  = wordDone && (wordIdx == '0);
  assign lastWord  = wordDone && !headWord && (wordIdx == ({1'b0, lenWords} + 1'b1));
  assign dataWord  = (wordDone && !lastWord);
  assign frameIdle = headWord ? (curWord[15:12] == 4'd0) : isIdle;
  assign badNow    = badPar | nibBad;
  assign vpOk      = (curWord == vpAcc);

  always_comb begin
    strobe      = '0;
    strobe.word = curWord;
    strobe.push = dataWord && !frameIdle && !specFull;
    if (lastWord && !isIdle) begin
      if (badNow || !vpOk || ovfFrame) strobe.rollback = 1'b1;
      else                             strobe.commit   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      nibCnt    <= '0;
      shReg     <= '0;
      wordIdx   <= '0;
      lenWords  <= '0;
      isIdle    <= 1'b0;
      badPar    <= 1'b0;
      ovfFrame  <= 1'b0;
      vpAcc     <= '0;
      ovfSticky <= 1'b0;
      acceptCnt <= '0;
      parErrCnt <= '0;
      dropCnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (linkSof) begin
          state    <= S_FRAME;
          nibCnt   <= 2'd1;
          shReg    <= {shReg[7:0], linkNib};
          wordIdx  <= '0;
          badPar   <= nibBad;
          ovfFrame <= 1'b0;
        end
        S_FRAME: begin
          nibCnt <= nibCnt + 1'b1;
          shReg  <= {shReg[7:0], linkNib};
          badPar <= badNow;
          if (wordDone) wordIdx <= wordIdx + 1'b1;
          if (headWord) begin
            lenWords <= curWord[LEN_W-1:0];
            isIdle   <= frameIdle;
            vpAcc    <= curWord;
          end else if (dataWord) begin
            vpAcc <= vpAcc ^ curWord;
          end
          if (dataWord && !frameIdle && specFull) ovfFrame <= 1'b1;
          if (lastWord) begin
            state <= S_IDLE;
            if (!isIdle) begin
              if (badNow || !vpOk) begin
                parErrCnt <= parErrCnt + 1'b1;
                dropCnt   <= dropCnt + 1'b1;
              end else if (ovfFrame) begin
                ovfSticky <= 1'b1;
                dropCnt   <= dropCnt + 1'b1;
              end else begin
                acceptCnt <= acceptCnt + 1'b1;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfSticky |=> ovfSticky);
  p_idle_nopush_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FRAME && isIdle && wordIdx != '0) |-> !strobe.push);
  p_drop_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> (dropCnt != $past(dropCnt)));
  p_accept_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (acceptCnt == $past(acceptCnt) + 1'b1));
  p_no_push_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !strobe.push);
endmodule

// File: rtl/fc_nib_rx.sv
module fc_nib_rx
  import fc_nib_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 4,
  parameter int CNT_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkSof,
  input  logic [3:0]        linkNib,
  input  logic              linkPar,
  input  logic [PTR_W:0]    hwmLevel,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              fcBackpressure,
  output logic              ovfSticky,
  output logic [CNT_W-1:0]  acceptCnt,
  output logic [CNT_W-1:0]  parErrCnt,
  output logic [CNT_W-1:0]  dropCnt
);
  fcStrobe_t strobe;
  logic      specFull;

  fc_nib_rx_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .linkSof(linkSof), .linkNib(linkNib),
    .linkPar(linkPar), .specFull(specFull), .strobe(strobe),
    .ovfSticky(ovfSticky), .acceptCnt(acceptCnt), .parErrCnt(parErrCnt),
    .dropCnt(dropCnt)
  );

  fc_nib_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEn(rdEn),
    .hwmLevel(hwmLevel), .rdData(rdData), .rdValid(rdValid),
    .specFull(specFull), .fcBackpressure(fcBackpressure)
  );
endmodule

// File: tb/fc_nib_rx_tb_top.sv
module fc_nib_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkSof = 1'b0;
  logic [3:0] linkNib = '0;
  logic linkPar = 1'b0;
  logic [4:0] hwmLevel = 5'd16;
  logic rdEn = 1'b0;
  logic [15:0] rdData;
  logic rdValid, fcBackpressure, ovfSticky;
  logic [7:0] acceptCnt, parErrCnt, dropCnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fc_nib_rx dut_i (
    .clk(clk), .rstN(rstN), .linkSof(linkSof), .linkNib(linkNib),
    .linkPar(linkPar), .hwmLevel(hwmLevel), .rdEn(rdEn), .rdData(rdData),
    .rdValid(rdValid), .fcBackpressure(fcBackpressure), .ovfSticky(ovfSticky),
    .acceptCnt(acceptCnt), .parErrCnt(parErrCnt), .dropCnt(dropCnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] payWord(input logic [7:0] tag, input int k);
    return {tag, tag} ^ (16'h1111 * 16'(k + 1));
  endfunction

  function automatic logic [15:0] hdrWord(input logic [3:0] typ, input logic [7:0] tag, input int len);
    return {typ, tag, 4'(len)};
  endfunction

  task automatic sendFrame(input logic [3:0] typ, input logic [7:0] tag, input int len,
                           input int badNib, input bit badVp, input int sofAgain);
    logic [15:0] w [18];
    logic [15:0] vp;
    w[0] = hdrWord(typ, tag, len);
    vp = w[0];
    for (int k = 0; k < len; k++) begin
      w[k + 1] = payWord(tag, k);
      vp ^= w[k + 1];
    end
    w[len + 1] = badVp ? (vp ^ 16'h0001) : vp;
    for (int j = 0; j < 4 * (len + 2); j++) begin
      logic [3:0] n;
      n = 4'(w[j / 4] >> (4 * (3 - (j % 4))));
      @(negedge clk);
      linkNib = n;
      linkSof = (j == 0) || (j == sofAgain);
      linkPar = (~^n) ^ (j == badNib);
    end
    @(negedge clk);
    linkSof = 1'b0;
    linkNib = 4'd0;
    linkPar = 1'b0;
  endtask

  task automatic popCheck(input logic [15:0] exp, input string req);
    check(rdValid === 1'b1, req, int'(rdValid), 1);
    check(rdData === exp, req, int'(rdData), int'(exp));
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    check(rdValid === 1'b0, "R10 reset rdValid", int'(rdValid), 0);
    check(fcBackpressure === 1'b0, "R9 reset bp", int'(fcBackpressure), 0);
    check(ovfSticky === 1'b0, "R8 reset sticky", int'(ovfSticky), 0);
    check(acceptCnt == 0 && parErrCnt == 0 && dropCnt == 0, "R6 reset counters",
          int'(acceptCnt) + int'(parErrCnt) + int'(dropCnt), 0);
  endtask

  task automatic testGood();
    sendFrame(4'h3, 8'hA5, 2, -1, 1'b0, -1);
    check(acceptCnt == 1, "R6 accept count", int'(acceptCnt), 1);
    popCheck(hdrWord(4'h3, 8'hA5, 2), "R2 header MSB-first");
    popCheck(payWord(8'hA5, 0), "R6 payload 0");
    popCheck(payWord(8'hA5, 1), "R6 payload 1");
    check(rdValid === 1'b0, "R10 empty after drain", int'(rdValid), 0);
  endtask

  task automatic testHoldUntilCheck();
    logic [15:0] w0;
    w0 = hdrWord(4'h2, 8'h11, 0);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      linkNib = 4'(w0 >> (4 * (3 - j)));
      linkSof = (j == 0);
      linkPar = ~^linkNib;
    end
    @(negedge clk);
    linkSof = 1'b0;
    linkNib = 4'(w0 >> 12);
    linkPar = ~^linkNib;
    check(rdValid === 1'b0, "R6 header not visible before check word", int'(rdValid), 0);
    for (int j = 1; j < 4; j++) begin
      @(negedge clk);
      linkNib = 4'(w0 >> (4 * (3 - j)));
      linkPar = ~^linkNib;
    end
    @(negedge clk);
    linkNib = 4'd0;
    linkPar = 1'b0;
    check(rdValid === 1'b1, "R4 zero-length frame committed", int'(rdValid), 1);
    popCheck(w0, "R4 zero-length header");
  endtask

  task automatic testNibPar();
    sendFrame(4'h5, 8'h3C, 3, 9, 1'b0, -1);
    check(parErrCnt == 1, "R3 parErrCnt", int'(parErrCnt), 1);
    check(dropCnt == 1, "R3 dropCnt", int'(dropCnt), 1);
    check(rdValid === 1'b0, "R3 nothing stored", int'(rdValid), 0);
  endtask

  task automatic testVp();
    sendFrame(4'h7, 8'h5A, 1, -1, 1'b1, -1);
    check(parErrCnt == 2, "R5 parErrCnt", int'(parErrCnt), 2);
    check(dropCnt == 2, "R5 dropCnt", int'(dropCnt), 2);
    check(rdValid === 1'b0, "R5 nothing stored", int'(rdValid), 0);
  endtask

  task automatic testIdle();
    sendFrame(4'h0, 8'h00, 0, -1, 1'b0, -1);
    sendFrame(4'h0, 8'h77, 2, -1, 1'b0, -1);
    check(rdValid === 1'b0, "R7 idle not stored", int'(rdValid), 0);
    check(acceptCnt == 2 && dropCnt == 2 && parErrCnt == 2, "R7 counters unchanged",
          int'(acceptCnt), 2);
  endtask

  task automatic testDeadSof();
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      linkSof = 1'b0;
      linkNib = 4'(j * 3 + 1);
      linkPar = 1'(j);
    end
    check(rdValid === 1'b0 && acceptCnt == 2, "R1 dead cycles ignored", int'(acceptCnt), 2);
    sendFrame(4'h9, 8'hC3, 1, -1, 1'b0, 5);
    check(acceptCnt == 3, "R1 mid-frame sof ignored", int'(acceptCnt), 3);
    popCheck(hdrWord(4'h9, 8'hC3, 1), "R1 header");
    popCheck(payWord(8'hC3, 0), "R1 payload");
  endtask

  task automatic testHwm();
    hwmLevel = 5'd3;
    @(negedge clk);
    check(fcBackpressure === 1'b0, "R9 empty below mark", int'(fcBackpressure), 0);
    sendFrame(4'h4, 8'h21, 1, -1, 1'b0, -1);
    check(fcBackpressure === 1'b0, "R9 two words below mark", int'(fcBackpressure), 0);
    sendFrame(4'h4, 8'h22, 0, -1, 1'b0, -1);
    check(fcBackpressure === 1'b1, "R9 three words at mark", int'(fcBackpressure), 1);
    popCheck(hdrWord(4'h4, 8'h21, 1), "R10 pop");
    check(fcBackpressure === 1'b0, "R9 released after pop", int'(fcBackpressure), 0);
    popCheck(payWord(8'h21, 0), "R10 pop");
    popCheck(hdrWord(4'h4, 8'h22, 0), "R10 pop");
    hwmLevel = 5'd16;
  endtask

  task automatic testOverflow();
    sendFrame(4'h6, 8'h99, 15, -1, 1'b0, -1);
    check(acceptCnt == 6, "R8 full frame accepted", int'(acceptCnt), 6);
    check(fcBackpressure === 1'b1, "R9 full at mark 16", int'(fcBackpressure), 1);
    sendFrame(4'h6, 8'h44, 0, -1, 1'b0, -1);
    check(ovfSticky === 1'b1, "R8 sticky set", int'(ovfSticky), 1);
    check(dropCnt == 3, "R8 dropCnt", int'(dropCnt), 3);
    check(acceptCnt == 6, "R8 no accept", int'(acceptCnt), 6);
    popCheck(hdrWord(4'h6, 8'h99, 15), "R8 earlier header intact");
    for (int k = 0; k < 15; k++) popCheck(payWord(8'h99, k), "R8 earlier payload intact");
    check(rdValid === 1'b0, "R8 dropped frame absent", int'(rdValid), 0);
    sendFrame(4'h1, 8'h10, 0, -1, 1'b0, -1);
    check(ovfSticky === 1'b1, "R8 sticky holds", int'(ovfSticky), 1);
    popCheck(hdrWord(4'h1, 8'h10, 0), "R8 recovery frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGood();
    testHoldUntilCheck();
    testNibPar();
    testVp();
    testIdle();
    testDeadSof();
    testHwm();
    testOverflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule